// File: doc/BRIEF.md
# DMA peripheral handshake responder

This block serves one peripheral request line on the controller side of a DMA engine. A peripheral signals demand with two level inputs: a burst request and a single request. The responder decides which kind of transaction the channel engine should run. It tells the engine with a one-cycle start strobe and two qualifier flags. It then waits for the engine to report that the data phase of the last bus transfer has finished, and returns an acknowledge to the peripheral.

The burst request always wins and is always treated as a burst. The single request counts only while the channel marks the current block transfer as being in its single-transaction region; outside that region it is ignored. A burst request seen inside that region is reported as an early-terminated burst. The acknowledge stays high for as long as the request that started the transaction stays high. Once that request drops, the acknowledge falls exactly one clock later. Only one transaction is outstanding at a time, and a new request is taken only after the acknowledge is low again. If a request drops before the acknowledge has been given, a one-cycle protocol-error pulse is raised.

Top module: `dma_hs_responder`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `start`, `ack` and `proto_err` are low.
- R2: With no transaction in progress, a high `burst_req` produces `start` high for exactly one cycle, in the cycle after the request is sampled. `start_single` is 0 with it, whatever the level of `single_req`.
- R3: `single_req` never causes `start` while `single_region` is low.
- R4: With no transaction in progress, `single_region` high, `single_req` high and `burst_req` low, the responder raises `start` in the next cycle with `start_single` = 1.
- R5: `start_early` is 1 with a burst `start` when `single_region` was high as the burst request was taken, and 0 when it was low.
- R6: `ack` rises in the cycle after a `last_done` pulse that arrives while a transaction is running; a `last_done` pulse with no transaction running leaves `ack` low.
- R7: After a burst, `ack` stays high while `burst_req` is high, and falls one cycle after the first cycle in which `burst_req` is sampled low.
- R8: After a single transaction, `ack` stays high while `single_req` is high, and falls one cycle after the first cycle in which `single_req` is sampled low.
- R9: No `start` is given in any cycle where `ack` was high in the previous cycle; a request reasserted while `ack` is still high starts only after `ack` has returned low.
- R10: If the request that began a transaction is sampled low before `ack` has risen, `proto_err` is high for exactly one cycle, in the next cycle, and only once per transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| burst_req | input | 1 | Level burst request from the peripheral |
| single_req | input | 1 | Level single request from the peripheral |
| single_region | input | 1 | High while the block transfer is in its single-transaction region |
| last_done | input | 1 | Pulse from the channel engine: last transfer data phase complete |
| start | output | 1 | One-cycle strobe telling the channel engine to begin a transaction |
| start_single | output | 1 | Transaction kind, valid with `start`: 1 single, 0 burst |
| start_early | output | 1 | Valid with `start`: burst taken inside the single-transaction region |
| ack | output | 1 | Acknowledge to the peripheral |
| proto_err | output | 1 | One-cycle pulse: request withdrawn before acknowledge |

## Verification
The assertions assume a peripheral that holds its request level until the acknowledge arrives, except in the deliberate early-drop case. They also assume a channel engine that pulses `last_done` at most once per transaction and only after `start`. The stimulus changes every input on the falling clock edge. It pulses `last_done` only once a transaction has been started, apart from one deliberate pulse while idle that must be ignored. It withdraws a request before acknowledge only in the scenario that checks the error pulse.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;

  typedef enum logic [2:0] {
    S_IDLE       = 3'd0,
    S_BURST_RUN  = 3'd1,
    S_SINGLE_RUN = 3'd2,
    S_ACK_HELD   = 3'd3,
    S_ACK_DROP   = 3'd4
  } hs_state_e;

endpackage

// File: rtl/dma_hs_classify.sv
module dma_hs_classify (
  input  logic burst_req,
  input  logic single_req,
  input  logic single_region,
  output logic go,
  output logic go_single,
  output logic go_early
);

  logic single_ok;

  always_comb begin
    // single demand counts only inside the single-transaction region
    single_ok = single_req && single_region;
    go        = burst_req || single_ok;
    // burst always has priority over single
    go_single = !burst_req && single_ok;
    go_early  = burst_req && single_region;
  end

endmodule

// File: rtl/dma_hs_err_mon.sv
module dma_hs_err_mon (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic match_req,
  output logic proto_err
);

  logic seen_q;
  logic err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (!active) begin
        seen_q <= 1'b0;
      end else if (!match_req && !seen_q) begin
        err_q  <= 1'b1;
        seen_q <= 1'b1;
      end
    end
  end

  assign proto_err = err_q;

  // R10
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |=> !err_q);

  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |-> $past(active && !match_req));

endmodule

// File: rtl/dma_hs_fsm.sv
module dma_hs_fsm
  import dma_hs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic burst_req,
  input  logic single_req,
  input  logic single_region,
  input  logic last_done,
  input  logic go,
  input  logic go_single,
  input  logic go_early,
  output logic start,
  output logic start_single,
  output logic start_early,
  output logic ack,
  output logic active,
  output logic match_req
);

  hs_state_e state_q;
  logic      start_q;
  logic      single_q;
  logic      early_q;
  logic      ack_q;

  always_comb begin
    match_req = single_q ? single_req : burst_req;
    active    = (state_q == S_BURST_RUN) || (state_q == S_SINGLE_RUN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      start_q  <= 1'b0;
      single_q <= 1'b0;
      early_q  <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      start_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (go) begin
            start_q  <= 1'b1;
            single_q <= go_single;
            early_q  <= go_early;
            state_q  <= go_single ? S_SINGLE_RUN : S_BURST_RUN;
          end
        end
        S_BURST_RUN, S_SINGLE_RUN: begin
          if (last_done) begin
            ack_q   <= 1'b1;
            state_q <= S_ACK_HELD;
          end
        end
        S_ACK_HELD: begin
          if (!match_req) state_q <= S_ACK_DROP;
        end
        S_ACK_DROP: begin
          ack_q   <= 1'b0;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign start        = start_q;
  assign start_single = single_q;
  assign start_early  = early_q;
  assign ack          = ack_q;

  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q);

  // R3
  single_region_chk: assert property (@(posedge clk) disable iff (rst)
    (start_q && single_q) |-> $past(single_region));

  // R5
  early_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (start_q && early_q) |-> $past(single_region && burst_req));

  // R6
  ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_q) |-> $past(last_done));

  // R7 R8
  ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_ACK_HELD && match_req) |=> ack_q);

  // R9
  start_gap_chk: assert property (@(posedge clk) disable iff (rst)
    start_q |-> $past(!ack_q));

endmodule

// File: rtl/dma_hs_responder.sv
module dma_hs_responder (
  input  logic clk,
  input  logic rst,
  input  logic burst_req,
  input  logic single_req,
  input  logic single_region,
  input  logic last_done,
  output logic start,
  output logic start_single,
  output logic start_early,
  output logic ack,
  output logic proto_err
);

  logic go;
  logic go_single;
  logic go_early;
  logic active;
  logic match_req;

  dma_hs_classify u_classify (
    .burst_req     (burst_req),
    .single_req    (single_req),
    .single_region (single_region),
    .go            (go),
    .go_single     (go_single),
    .go_early      (go_early)
  );

  dma_hs_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .burst_req     (burst_req),
    .single_req    (single_req),
    .single_region (single_region),
    .last_done     (last_done),
    .go            (go),
    .go_single     (go_single),
    .go_early      (go_early),
    .start         (start),
    .start_single  (start_single),
    .start_early   (start_early),
    .ack           (ack),
    .active        (active),
    .match_req     (match_req)
  );

  dma_hs_err_mon u_err (
    .clk       (clk),
    .rst       (rst),
    .active    (active),
    .match_req (match_req),
    .proto_err (proto_err)
  );

endmodule

// File: tb/test_dma_hs_responder.sv
module test_dma_hs_responder;

  logic clk = 1'b0;
  logic rst;
  logic burst_req, single_req, single_region, last_done;
  logic start, start_single, start_early, ack, proto_err;
  int   n_checks = 0;
  int   n_errs   = 0;
  bit   done     = 1'b0;

  always #5 clk = ~clk;

  dma_hs_responder i_dma_hs_responder (
    .clk           (clk),
    .rst           (rst),
    .burst_req     (burst_req),
    .single_req    (single_req),
    .single_region (single_region),
    .last_done     (last_done),
    .start         (start),
    .start_single  (start_single),
    .start_early   (start_early),
    .ack           (ack),
    .proto_err     (proto_err)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic finish_burst();
    last_done = 1'b1;
    @(negedge clk);
    last_done = 1'b0;
    burst_req = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; burst_req = 0; single_req = 0; single_region = 0; last_done = 0;
    repeat (3) @(negedge clk);
    check("R1 start in reset", start, 1'b0);
    check("R1 ack in reset", ack, 1'b0);
    check("R1 proto_err in reset", proto_err, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 start after reset", start, 1'b0);
    check("R1 ack after reset", ack, 1'b0);
    check("R1 proto_err after reset", proto_err, 1'b0);
  endtask

  task automatic t_idle_done();
    last_done = 1'b1;
    @(negedge clk);
    last_done = 1'b0;
    check("R6 ack ignores idle last_done", ack, 1'b0);
    @(negedge clk);
    check("R6 ack still low", ack, 1'b0);
  endtask

  task automatic t_burst();
    burst_req = 1'b1; single_req = 1'b1; single_region = 1'b0;
    @(negedge clk);
    check("R2 burst start", start, 1'b1);
    check("R2 burst kind", start_single, 1'b0);
    check("R5 no early outside region", start_early, 1'b0);
    @(negedge clk);
    check("R2 start one cycle", start, 1'b0);
    @(negedge clk);
    check("R6 no ack before last_done", ack, 1'b0);
    last_done = 1'b1;
    @(negedge clk);
    last_done = 1'b0;
    check("R6 ack after last_done", ack, 1'b1);
    repeat (2) begin
      @(negedge clk);
      check("R7 ack held while burst_req", ack, 1'b1);
    end
    burst_req = 1'b0; single_req = 1'b0;
    @(negedge clk);
    check("R7 ack one more cycle", ack, 1'b1);
    burst_req = 1'b1;
    @(negedge clk);
    check("R7 ack released", ack, 1'b0);
    check("R9 no start while ack was high", start, 1'b0);
    @(negedge clk);
    check("R9 start after ack low", start, 1'b1);
    finish_burst();
    check("R7 idle after finish", ack, 1'b0);
  endtask

  task automatic t_single();
    burst_req = 1'b0; single_region = 1'b0; single_req = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check("R3 single ignored outside region", start, 1'b0);
    end
    single_region = 1'b1;
    @(negedge clk);
    check("R4 single start", start, 1'b1);
    check("R4 single kind", start_single, 1'b1);
    last_done = 1'b1;
    @(negedge clk);
    last_done = 1'b0;
    check("R6 single ack", ack, 1'b1);
    repeat (2) begin
      @(negedge clk);
      check("R8 ack held while single_req", ack, 1'b1);
    end
    single_req = 1'b0;
    @(negedge clk);
    check("R8 ack one more cycle", ack, 1'b1);
    @(negedge clk);
    check("R8 ack released", ack, 1'b0);
    single_region = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_early();
    single_region = 1'b1; single_req = 1'b0; burst_req = 1'b1;
    @(negedge clk);
    check("R5 early start", start, 1'b1);
    check("R5 early kind burst", start_single, 1'b0);
    check("R5 early flag", start_early, 1'b1);
    finish_burst();
    single_region = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_proto();
    burst_req = 1'b1;
    @(negedge clk);
    check("R10 start before drop", start, 1'b1);
    check("R10 no error yet", proto_err, 1'b0);
    burst_req = 1'b0;
    @(negedge clk);
    check("R10 error pulse", proto_err, 1'b1);
    @(negedge clk);
    check("R10 error one cycle", proto_err, 1'b0);
    @(negedge clk);
    check("R10 error once", proto_err, 1'b0);
    last_done = 1'b1;
    @(negedge clk);
    last_done = 1'b0;
    check("R6 ack after early drop", ack, 1'b1);
    @(negedge clk);
    check("R7 ack one cycle after low", ack, 1'b1);
    @(negedge clk);
    check("R7 ack released after drop", ack, 1'b0);
    check("R10 no error at release", proto_err, 1'b0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle_done();
    t_burst();
    t_single();
    t_early();
    t_proto();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

endmodule